// File: doc/BRIEF.md
# Dual-Flag Adder/Subtracter

This block adds or subtracts two N-bit operands through a single carry-lookahead adder. One mode input chooses the operation. To subtract, every bit of the second operand is inverted and the carry into the least significant bit is held high. The same adder therefore serves both operations, and its carries produce two flags.

The first flag, `uflow`, treats the operands as unsigned numbers. It is high when the true result cannot be represented in N bits. The second flag, `sovf`, treats the operands as two's-complement numbers and is high on a signed overflow. Because both flags come from one datapath, the same word can be read under either interpretation.

The adder core groups bits in fours. Each group forms its carries in expanded generate/propagate form. A second lookahead level spans the groups, so no carry ripples through more than one level of gates per tier. The block is purely combinational.

Top module: `addsub_dual_flag`

## Requirements
- R1: With `sub_mode` = 0 (add), `sum` equals (x + y) mod 2^N.
- R2: With `sub_mode` = 0, `uflow` equals the carry out of bit N-1, so it is 1 exactly when x + y >= 2^N.
- R3: With `sub_mode` = 1 (subtract), `sum` equals (x - y) mod 2^N.
- R4: With `sub_mode` = 1, `uflow` is 1 exactly when x < y as unsigned values, which means the carry out of the complemented-operand addition is 0.
- R5: In add mode, `sovf` is 1 exactly when x and y have the same sign bit and the sign bit of `sum` differs from it.
- R6: In subtract mode, `sovf` is 1 exactly when the sign bits of x and y differ and the sign bit of `sum` differs from that of x.
- R7: Subtracting the most negative value (only bit N-1 set) from 0 returns the most negative value, with `sovf` = 1 and `uflow` = 1.
- R8: Subtracting any value from itself gives `sum` = 0, `uflow` = 0 and `sovf` = 0.
- R9: The default width N = 12 is built from three 4-bit lookahead groups. Widths that are not a multiple of 4 give the same results as R1 to R6. This is shown at N = 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | First operand |
| y | input | N | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum | output | N | Sum or difference, modulo 2^N |
| uflow | output | 1 | Unsigned result out of range (carry in add mode, borrow in subtract mode) |
| sovf | output | 1 | Two's-complement overflow |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus and has no register latency. The bench applies each operand pair just after a rising clock edge and samples one nanosecond later, once the lookahead logic has settled and well before the next edge. Two instances run side by side: a 6-bit one driven through every operand pair in both modes, and the default 12-bit one driven with seeded random pairs and directed sign-boundary cases.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

    localparam int unsigned GRP_W = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic uflow;
        logic sovf;
    } flags_t;

    function automatic int unsigned grp_count(input int unsigned width);
        return (width + GRP_W - 1) / GRP_W;
    endfunction

endpackage

// File: rtl/lookahead_carry.sv
`timescale 1ns/1ps
// Flat lookahead: every carry is a sum of products of generate, propagate
// and the incoming carry, with no carry feeding another.
module lookahead_carry #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W-1:0] carry,
    output logic         grp_gen,
    output logic         grp_prop
);

    always_comb begin : expand_blk
        logic acc;
        logic term;
        carry = '0;
        for (int k = 0; k < int'(W); k++) begin
            acc = cin;
            for (int m = 0; m < k; m++) acc = acc & prop[m];
            for (int j = 0; j < k; j++) begin
                term = gen[j];
                for (int m = j + 1; m < k; m++) term = term & prop[m];
                acc = acc | term;
            end
            carry[k] = acc;
        end
    end

    always_comb begin : group_blk
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < int'(W); j++) begin
            term = gen[j];
            for (int m = j + 1; m < int'(W); m++) term = term & prop[m];
            acc = acc | term;
        end
        grp_gen  = acc;
        grp_prop = &prop;
    end

endmodule

// File: rtl/cla_group.sv
`timescale 1ns/1ps
module cla_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         grp_gen,
    output logic         grp_prop
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_carry;

    assign bit_gen  = a & b;
    assign bit_prop = a ^ b;

    lookahead_carry #(.W(W)) la_i (
        .gen      (bit_gen),
        .prop     (bit_prop),
        .cin      (cin),
        .carry    (bit_carry),
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop)
    );

    assign sum = bit_prop ^ bit_carry;

endmodule

// File: rtl/operand_prep.sv
`timescale 1ns/1ps
// Inverts y for subtraction and widens both operands to a whole number of
// groups. Pad bits are x=1, y=0 so that they pass a carry straight through.
module operand_prep #(
    parameter int unsigned N  = 12,
    parameter int unsigned PW = 12
) (
    input  logic [N-1:0]  x,
    input  logic [N-1:0]  y,
    input  logic          sub_mode,
    output logic [PW-1:0] a_pad,
    output logic [PW-1:0] b_pad,
    output logic          b_msb
);

    logic [N-1:0] y_eff;

    assign y_eff = sub_mode ? ~y : y;

    generate
        if (PW > N) begin : g_pad
            assign a_pad = {{(PW-N){1'b1}}, x};
            assign b_pad = {{(PW-N){1'b0}}, y_eff};
        end else begin : g_exact
            assign a_pad = x;
            assign b_pad = y_eff;
        end
    endgenerate

    assign b_msb = y_eff[N-1];

endmodule

// File: rtl/addsub_dual_flag.sv
`timescale 1ns/1ps
module addsub_dual_flag
    import addsub_pkg::*;
#(
    parameter int unsigned N = 12
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         sub_mode,
    output logic [N-1:0] sum,
    output logic         uflow,
    output logic         sovf
);

    localparam int unsigned NG = grp_count(N);
    localparam int unsigned PW = NG * GRP_W;

    typedef struct packed {
        logic [N-1:0] sum;
        flags_t       flags;
    } result_t;

    logic [PW-1:0] a_pad;
    logic [PW-1:0] b_pad;
    logic          b_msb;
    logic [PW-1:0] sum_pad;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG-1:0] grp_cin;
    logic          all_g;
    logic          all_p;
    logic          cout;
    op_e           op;
    result_t       res_d;

    assign op = op_e'(sub_mode);

    operand_prep #(.N(N), .PW(PW)) prep_i (
        .x        (x),
        .y        (y),
        .sub_mode (sub_mode),
        .a_pad    (a_pad),
        .b_pad    (b_pad),
        .b_msb    (b_msb)
    );

    generate
        for (genvar k = 0; k < int'(NG); k++) begin : g_grp
            cla_group #(.W(GRP_W)) grp_i (
                .a        (a_pad[k*GRP_W +: GRP_W]),
                .b        (b_pad[k*GRP_W +: GRP_W]),
                .cin      (grp_cin[k]),
                .sum      (sum_pad[k*GRP_W +: GRP_W]),
                .grp_gen  (grp_g[k]),
                .grp_prop (grp_p[k])
            );
        end
    endgenerate

    // Second lookahead level: carry into each group from group terms.
    lookahead_carry #(.W(NG)) top_la_i (
        .gen      (grp_g),
        .prop     (grp_p),
        .cin      (sub_mode),
        .carry    (grp_cin),
        .grp_gen  (all_g),
        .grp_prop (all_p)
    );

    // Pad bits propagate, so the carry out of the padded word is the carry out of bit N-1.
    assign cout = all_g | (all_p & sub_mode);

    always_comb begin
        res_d.sum = sum_pad[N-1:0];
        // Carry into the sign bit is recovered as sum ^ propagate of that bit.
        res_d.flags.sovf  = cout ^ (sum_pad[N-1] ^ x[N-1] ^ b_msb);
        res_d.flags.uflow = (op == OP_SUB) ? ~cout : cout;
    end

    assign sum   = res_d.sum;
    assign uflow = res_d.flags.uflow;
    assign sovf  = res_d.flags.sovf;

endmodule

// File: rtl/addsub_dual_flag_chk.sv
`timescale 1ns/1ps
module addsub_dual_flag_chk #(
    parameter int unsigned N = 12
) (
    input logic [N-1:0] x,
    input logic [N-1:0] y,
    input logic         sub_mode,
    input logic [N-1:0] sum,
    input logic         uflow,
    input logic         sovf
);

    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

    always_comb begin
        if (!sub_mode) begin
            assert_add_result_R1_R2: assert ({uflow, sum} == ({1'b0, x} + {1'b0, y}))
                else $error("R1/R2 add result mismatch");
            assert_add_sovf_R5: assert (sovf == ((x[N-1] == y[N-1]) && (sum[N-1] != x[N-1])))
                else $error("R5 add overflow flag mismatch");
        end else begin
            assert_sub_diff_R3: assert (sum == N'(x - y))
                else $error("R3 difference mismatch");
            assert_sub_borrow_R4: assert (uflow == (x < y))
                else $error("R4 borrow flag mismatch");
            assert_sub_sovf_R6: assert (sovf == ((x[N-1] != y[N-1]) && (sum[N-1] != x[N-1])))
                else $error("R6 subtract overflow flag mismatch");
            if (x == '0 && y == MOST_NEG) begin
                assert_neg_wrap_R7: assert (sum == MOST_NEG && sovf && uflow)
                    else $error("R7 most-negative negation mismatch");
            end
            if (x == y) begin
                assert_self_sub_R8: assert (sum == '0 && !uflow && !sovf)
                    else $error("R8 self subtraction mismatch");
            end
        end
    end

endmodule

bind addsub_dual_flag addsub_dual_flag_chk #(.N(N)) chk_i (
    .x        (x),
    .y        (y),
    .sub_mode (sub_mode),
    .sum      (sum),
    .uflow    (uflow),
    .sovf     (sovf)
);

// File: tb/addsub_dual_flag_tb_top.sv
`timescale 1ns/1ps
module addsub_dual_flag_tb_top;

    localparam int unsigned NW = 12;
    localparam int unsigned NS = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [NW-1:0] xw, yw, sumw;
    logic          subw, ufw, sfw;
    logic [NS-1:0] xs, ys, sums;
    logic          subs, ufs, sfs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    addsub_dual_flag #(.N(NW)) dut_i (
        .x(xw), .y(yw), .sub_mode(subw), .sum(sumw), .uflow(ufw), .sovf(sfw)
    );

    addsub_dual_flag #(.N(NS)) dut6_i (
        .x(xs), .y(ys), .sub_mode(subs), .sum(sums), .uflow(ufs), .sovf(sfs)
    );

    // Reference model on plain integers, width n.
    function automatic int exp_sum(int n, int a, int b, bit sb);
        int mask = (1 << n) - 1;
        return (sb ? (a - b) : (a + b)) & mask;
    endfunction

    function automatic bit exp_uflow(int n, int a, int b, bit sb);
        if (sb) return a < b;
        return (a + b) >= (1 << n);
    endfunction

    function automatic bit exp_sovf(int n, int a, int b, bit sb);
        int sa = (a >= (1 << (n-1))) ? a - (1 << n) : a;
        int sbv = (b >= (1 << (n-1))) ? b - (1 << n) : b;
        int r = sb ? sa - sbv : sa + sbv;
        return (r > (1 << (n-1)) - 1) || (r < -(1 << (n-1)));
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_w(string tag, int a, int b, bit sb);
        chk({tag, (sb ? " R3 sum" : " R1 sum")}, int'(sumw), exp_sum(NW, a, b, sb));
        chk({tag, (sb ? " R4 uflow" : " R2 uflow")}, int'(ufw), int'(exp_uflow(NW, a, b, sb)));
        chk({tag, (sb ? " R6 sovf" : " R5 sovf")}, int'(sfw), int'(exp_sovf(NW, a, b, sb)));
    endtask

    task automatic apply_w(string tag, int a, int b, bit sb);
        @(posedge clk);
        xw = NW'(a); yw = NW'(b); subw = sb;
        #1;
        check_w(tag, a, b, sb);
    endtask

    initial begin
        xw = '0; yw = '0; subw = 1'b0;
        xs = '0; ys = '0; subs = 1'b0;
        #1;
        // Zero inputs in add mode: all outputs zero (R1 R2 R5)
        chk("R1 zero sum", int'(sumw), 0);
        chk("R2 zero uflow", int'(ufw), 0);
        chk("R5 zero sovf", int'(sfw), 0);

        // R7: 0 minus most negative wraps to itself with both flags set
        apply_w("R7", 0, 'h800, 1'b1);
        chk("R7 sum wraps", int'(sumw), 'h800);
        chk("R7 sovf", int'(sfw), 1);
        chk("R7 uflow", int'(ufw), 1);

        // R8: self subtraction
        apply_w("R8", 'h5A5, 'h5A5, 1'b1);
        chk("R8 sum zero", int'(sumw), 0);
        chk("R8 uflow clear", int'(ufw), 0);
        chk("R8 sovf clear", int'(sfw), 0);

        // Directed sign and carry boundaries
        apply_w("edge", 'h7FF, 'h001, 1'b0);
        apply_w("edge", 'hFFF, 'h001, 1'b0);
        apply_w("edge", 'h800, 'h800, 1'b0);
        apply_w("edge", 'h800, 'h001, 1'b1);
        apply_w("edge", 'h7FF, 'hFFF, 1'b1);
        apply_w("edge", 'h000, 'h001, 1'b1);
        apply_w("edge", 'hFFF, 'hFFF, 1'b0);

        // Seeded random vectors at width 12
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 20000; i++) begin
            apply_w("rand", int'($urandom_range(4095)), int'($urandom_range(4095)), 1'($urandom_range(1)));
        end

        // R9: exhaustive sweep at width 6 (not a multiple of the group size)
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    @(posedge clk);
                    xs = NS'(a); ys = NS'(b); subs = m[0];
                    #1;
                    chk(m[0] ? "R9 R3 sum6" : "R9 R1 sum6", int'(sums), exp_sum(NS, a, b, m[0]));
                    chk(m[0] ? "R9 R4 uflow6" : "R9 R2 uflow6", int'(ufs), int'(exp_uflow(NS, a, b, m[0])));
                    chk(m[0] ? "R9 R6 sovf6" : "R9 R5 sovf6", int'(sfs), int'(exp_sovf(NS, a, b, m[0])));
                end
            end
        end

        // R7 at width 6 as well
        @(posedge clk);
        xs = '0; ys = 6'h20; subs = 1'b1;
        #1;
        chk("R7 sum6", int'(sums), 'h20);
        chk("R7 sovf6", int'(sfs), 1);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule